// File: doc/BRIEF.md
# Set-Associative Cache Tag Store

This block holds the tag half of a set-associative cache: one valid bit, one tag, one owner ID and one fill-pending countdown per line, plus per-set recency state. A requester issues one operation at a time on a request port: a normal access, a probe, a fill or an invalidate. The block answers with a single response pulse that carries hit and way, the victim way for that set, an access latency, and the number of tag and data ways touched. Data storage, coherence beyond valid, and miss handling stay outside.

The address splits into a block offset (ignored), a set index and a tag. Only ways below a programmable allocation limit take part in lookup and replacement. A probe reports without side effects. An access refreshes the recency of the way it hits. A fill writes the hit way, or the victim if there is no hit, and makes that way the most recent. Per-requester occupancy counters follow fills, evictions and invalidates. A read-back port rebuilds the block address held in any set and way.

Control is a two-state machine. ST_IDLE accepts a request when `req_valid` is high and moves to ST_EXEC (transition ACCEPT). ST_EXEC evaluates the captured request, commits its updates, registers the response and always returns to ST_IDLE (transition RETIRE). A request is therefore accepted at most every second cycle. Its response is valid for one cycle, on the second clock edge after acceptance.

Top module: `set_assoc_tags`

## Requirements
- R1: The tag is `addr >> (OFFSET_W+SET_W)` (bits 31:10 by default) and the set is `(addr >> OFFSET_W) & (SETS-1)` (bits 9:6). Offset bits 5:0 have no effect on any result.
- R2: For a chosen set and way, the read-back port combinationally returns `(tag << (OFFSET_W+SET_W)) | (set << OFFSET_W)`, along with that line's valid bit and owner.
- R3: Operation codes are 0 access, 1 probe, 2 fill and 3 invalidate. `req_ready` is high only in ST_IDLE. `rsp_valid` pulses for one cycle two edges after acceptance. `rsp_hit`/`rsp_way` give the lowest allocatable valid way whose tag matches.
- R4: `rsp_victim` is the lowest invalid way below the limit. If every such way is valid, it is the least recently used of them.
- R5: After reset the recency order is way 0 most recent through way WAYS-1 least recent. An access hit and a fill each make the touched way the most recent.
- R6: A probe reports hit, way and victim but leaves the recency order unchanged.
- R7: The allocation limit resets to WAYS. A write of 0 or of more than WAYS is ignored and the previous limit is kept.
- R8: Ways at or above the limit never hit and are never chosen as victim or fill target.
- R9: Access and probe report `rsp_treads` equal to the limit. In sequential mode `rsp_dreads` is 1 on a hit and 0 on a miss; in parallel mode it equals the limit. Fill and invalidate report 0 for both.
- R10: A fill stores the tag, sets valid, records `req_id` as owner and increments that requester's counter. If the target was valid, it decrements the previous owner's counter. Counter r sits at `occ_flat[r*CNT_W +: CNT_W]`.
- R11: An invalidate that hits clears valid, clears the owner to 0 and decrements the old owner's counter. An invalidate that misses changes nothing.
- R12: A fill loads the line's pending countdown with `req_wait`, and the countdown drops by one every cycle. On a hit, `rsp_lat` is remaining+ACC_LAT when the remaining count exceeds ACC_LAT, and ACC_LAT otherwise. A miss reports ACC_LAT.
- R13: Reset clears every valid bit, owner, countdown and occupancy counter, and puts the machine in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept (ST_IDLE) |
| req_op | input | 2 | 0 access, 1 probe, 2 fill, 3 invalidate |
| req_addr | input | ADDR_W | Byte address |
| req_id | input | REQ_W | Requester ID for fill |
| req_wait | input | WAIT_W | Pending cycles loaded on fill |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Tag matched an allocatable valid way |
| rsp_way | output | WAY_W | Hit way, or way written by a fill |
| rsp_victim | output | WAY_W | Replacement candidate for the set |
| rsp_lat | output | WAIT_W+1 | Access latency in cycles |
| rsp_treads | output | WAY_W+1 | Tag ways read |
| rsp_dreads | output | WAY_W+1 | Data ways read |
| lim_we | input | 1 | Write allocation limit |
| lim_val | input | WAY_W+1 | New allocation limit |
| alloc_lim | output | WAY_W+1 | Current allocation limit |
| rb_set | input | SET_W | Read-back set |
| rb_way | input | WAY_W | Read-back way |
| rb_addr | output | ADDR_W | Rebuilt block address |
| rb_valid | output | 1 | Valid bit of that line |
| rb_owner | output | REQ_W | Owner of that line |
| occ_flat | output | NUM_REQ*CNT_W | Packed occupancy counters |

## Verification
The bench uses the default sizing: 4 ways, 16 sets, a 6-bit offset, 4 requesters and a 4-bit pending countdown. With 64 lines in total, every line can be filled, read back and counted, and every set can be driven into full-set LRU eviction. A second instance built in parallel access mode receives the same stimulus, so both data-read rules are checked on identical traffic. A countdown of 15 against an access latency of 2 brings both sides of the pending-latency rule within reach, and limits of 2 and 4 expose the masking of the upper ways.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_PROBE  = 2'd1,
        OP_FILL   = 2'd2,
        OP_INVAL  = 2'd3
    } sat_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } sat_state_e;

endpackage

// File: rtl/sat_match.sv
module sat_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int WAY_W = 2,
    parameter int LIM_W = 3
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    input  logic [LIM_W-1:0]           lim,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] match;

    // one comparator per way, all in parallel
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag) && (LIM_W'(w) < lim);
    end

    always_comb begin
        hit = |match;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sat_victim.sv
module sat_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int LIM_W = 3
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    input  logic [LIM_W-1:0]           lim,
    output logic [WAY_W-1:0]           victim
);
    logic [WAYS-1:0] allow;
    logic [WAYS-1:0] free;

    for (genvar w = 0; w < WAYS; w++) begin : g_allow
        assign allow[w] = LIM_W'(w) < lim;
        assign free[w]  = allow[w] && !valid[w];
    end

    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic [WAY_W-1:0] old_age;
    logic             old_found;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (free[w]) free_way = WAY_W'(w);
        end
        old_way   = '0;
        old_age   = '0;
        old_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (allow[w] && (!old_found || age[w] > old_age)) begin
                old_way   = WAY_W'(w);
                old_age   = age[w];
                old_found = 1'b1;
            end
        end
        victim = (|free) ? free_way : old_way;
    end
endmodule

// File: rtl/sat_lru.sv
module sat_lru #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][WAY_W-1:0] rd_age,
    input  logic                       touch_en,
    input  logic [SET_W-1:0]           touch_set,
    input  logic [WAY_W-1:0]           touch_way
);
    // age 0 = most recent; ages within a set always form a permutation
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

    assign rd_age = age_q[rd_set];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAY_W-1:0] ref_age;
        assign ref_age = age_q[s][touch_way];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end else if (touch_en && (touch_set == SET_W'(s))) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[s][w] <= '0;
                    else if (age_q[s][w] < ref_age)
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sat_occ.sv
module sat_occ #(
    parameter int NUM_REQ = 4,
    parameter int REQ_W   = 2,
    parameter int CNT_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc_en,
    input  logic [REQ_W-1:0]         inc_id,
    input  logic                     dec_en,
    input  logic [REQ_W-1:0]         dec_id,
    output logic [NUM_REQ*CNT_W-1:0] cnt_flat
);
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             up;
        logic             dn;

        assign up = inc_en && (inc_id == REQ_W'(r));
        assign dn = dec_en && (dec_id == REQ_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (up && !dn)
                cnt_q <= cnt_q + 1'b1;
            else if (dn && !up)
                cnt_q <= cnt_q - 1'b1;
        end

        assign cnt_flat[r*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/set_assoc_tags.sv
module set_assoc_tags #(
    parameter int ADDR_W     = 32,
    parameter int OFFSET_W   = 6,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int NUM_REQ    = 4,
    parameter int WAIT_W     = 4,
    parameter int ACC_LAT    = 2,
    parameter bit SEQ_ACCESS = 1'b1,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LIM_W  = WAY_W + 1,
    localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int CNT_W  = $clog2(SETS * WAYS + 1),
    localparam int LAT_W  = WAIT_W + 1,
    localparam int TAG_SH = OFFSET_W + SET_W,
    localparam int TAG_W  = ADDR_W - TAG_SH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [REQ_W-1:0]         req_id,
    input  logic [WAIT_W-1:0]        req_wait,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [WAY_W-1:0]         rsp_way,
    output logic [WAY_W-1:0]         rsp_victim,
    output logic [LAT_W-1:0]         rsp_lat,
    output logic [LIM_W-1:0]         rsp_treads,
    output logic [LIM_W-1:0]         rsp_dreads,
    input  logic                     lim_we,
    input  logic [LIM_W-1:0]         lim_val,
    output logic [LIM_W-1:0]         alloc_lim,
    input  logic [SET_W-1:0]         rb_set,
    input  logic [WAY_W-1:0]         rb_way,
    output logic [ADDR_W-1:0]        rb_addr,
    output logic                     rb_valid,
    output logic [REQ_W-1:0]         rb_owner,
    output logic [NUM_REQ*CNT_W-1:0] occ_flat
);
    import sat_pkg::*;

    // ---------------- line storage ----------------
    logic [SETS-1:0][WAYS-1:0]              valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
    logic [SETS-1:0][WAYS-1:0][REQ_W-1:0]   owner_q;
    logic [SETS-1:0][WAYS-1:0][WAIT_W-1:0]  pend_q;

    // ---------------- control state ----------------
    sat_state_e         state_q, state_d;
    sat_op_e            op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [REQ_W-1:0]   id_q;
    logic [WAIT_W-1:0]  wait_q;
    logic [LIM_W-1:0]   lim_q;

    logic               accept;
    logic               exec;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign exec      = (state_q == ST_EXEC);

    // ---------------- address split ----------------
    logic [SET_W-1:0] cur_set;
    logic [TAG_W-1:0] cur_tag;

    assign cur_set = SET_W'((addr_q >> OFFSET_W) & ADDR_W'(SETS - 1));
    assign cur_tag = TAG_W'(addr_q >> TAG_SH);

    // ---------------- per-set compare and victim ----------------
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim;
    logic [WAYS-1:0][WAY_W-1:0] set_age;

    sat_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W),
        .LIM_W (LIM_W)
    ) match_i (
        .valid (valid_q[cur_set]),
        .tags  (tag_q[cur_set]),
        .tag   (cur_tag),
        .lim   (lim_q),
        .hit   (hit),
        .way   (hit_way)
    );

    sat_victim #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W),
        .LIM_W (LIM_W)
    ) victim_i (
        .valid  (valid_q[cur_set]),
        .age    (set_age),
        .lim    (lim_q),
        .victim (victim)
    );

    // ---------------- operation decode ----------------
    logic             is_look;
    logic             do_fill;
    logic             do_inval;
    logic [WAY_W-1:0] fill_way;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic             occ_inc;
    logic             occ_dec;
    logic [REQ_W-1:0] occ_dec_id;

    assign is_look   = (op_q == OP_ACCESS) || (op_q == OP_PROBE);
    assign do_fill   = exec && (op_q == OP_FILL);
    assign do_inval  = exec && (op_q == OP_INVAL) && hit;
    assign fill_way  = hit ? hit_way : victim;
    assign touch_en  = do_fill || (exec && (op_q == OP_ACCESS) && hit);
    assign touch_way = do_fill ? fill_way : hit_way;

    assign occ_inc    = do_fill;
    assign occ_dec    = do_inval || (do_fill && valid_q[cur_set][fill_way]);
    assign occ_dec_id = do_inval ? owner_q[cur_set][hit_way]
                                 : owner_q[cur_set][fill_way];

    sat_lru #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) lru_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (cur_set),
        .rd_age    (set_age),
        .touch_en  (touch_en),
        .touch_set (cur_set),
        .touch_way (touch_way)
    );

    sat_occ #(
        .NUM_REQ (NUM_REQ),
        .REQ_W   (REQ_W),
        .CNT_W   (CNT_W)
    ) occ_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (occ_inc),
        .inc_id   (id_q),
        .dec_en   (occ_dec),
        .dec_id   (occ_dec_id),
        .cnt_flat (occ_flat)
    );

    // ---------------- response values ----------------
    logic [LAT_W-1:0] remain;
    logic [LAT_W-1:0] lat_d;
    logic [LIM_W-1:0] treads_d;
    logic [LIM_W-1:0] dreads_d;

    assign remain = LAT_W'(pend_q[cur_set][hit_way]);

    always_comb begin
        if (hit && (remain > LAT_W'(ACC_LAT)))
            lat_d = remain + LAT_W'(ACC_LAT);
        else
            lat_d = LAT_W'(ACC_LAT);

        treads_d = is_look ? lim_q : '0;
        if (!is_look)
            dreads_d = '0;
        else if (SEQ_ACCESS)
            dreads_d = hit ? LIM_W'(1) : '0;
        else
            dreads_d = lim_q;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;   // ACCEPT
            ST_EXEC: state_d = ST_IDLE;                 // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_ACCESS;
            addr_q <= '0;
            id_q   <= '0;
            wait_q <= '0;
        end else if (accept) begin
            op_q   <= sat_op_e'(req_op);
            addr_q <= req_addr;
            id_q   <= req_id;
            wait_q <= req_wait;
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_victim <= '0;
            rsp_lat    <= '0;
            rsp_treads <= '0;
            rsp_dreads <= '0;
        end else begin
            rsp_valid <= exec;
            if (exec) begin
                rsp_hit    <= hit;
                rsp_way    <= (op_q == OP_FILL) ? fill_way : hit_way;
                rsp_victim <= victim;
                rsp_lat    <= lat_d;
                rsp_treads <= treads_d;
                rsp_dreads <= dreads_d;
            end
        end
    end

    // ---------------- allocation limit ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lim_q <= LIM_W'(WAYS);
        else if (lim_we && (lim_val != '0) && (lim_val <= LIM_W'(WAYS)))
            lim_q <= lim_val;
    end

    assign alloc_lim = lim_q;

    // ---------------- line update ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            owner_q <= '0;
            pend_q  <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (pend_q[s][w] != '0) pend_q[s][w] <= pend_q[s][w] - 1'b1;
                end
            end
            if (do_fill) begin
                valid_q[cur_set][fill_way] <= 1'b1;
                tag_q[cur_set][fill_way]   <= cur_tag;
                owner_q[cur_set][fill_way] <= id_q;
                pend_q[cur_set][fill_way]  <= wait_q;
            end
            if (do_inval) begin
                valid_q[cur_set][hit_way] <= 1'b0;
                owner_q[cur_set][hit_way] <= '0;
                pend_q[cur_set][hit_way]  <= '0;
            end
        end
    end

    // ---------------- read-back ----------------
    assign rb_addr  = (ADDR_W'(tag_q[rb_set][rb_way]) << TAG_SH)
                    | (ADDR_W'(rb_set) << OFFSET_W);
    assign rb_valid = valid_q[rb_set][rb_way];
    assign rb_owner = owner_q[rb_set][rb_way];

endmodule

// File: rtl/sat_chk.sv
module sat_chk #(
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int NUM_REQ    = 4,
    parameter int ACC_LAT    = 2,
    parameter bit SEQ_ACCESS = 1'b1,
    parameter int WAY_W      = 2,
    parameter int LIM_W      = 3,
    parameter int CNT_W      = 7,
    parameter int LAT_W      = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic [WAY_W-1:0]         rsp_way,
    input logic [WAY_W-1:0]         rsp_victim,
    input logic [LAT_W-1:0]         rsp_lat,
    input logic [LIM_W-1:0]         rsp_treads,
    input logic [LIM_W-1:0]         rsp_dreads,
    input logic [LIM_W-1:0]         alloc_lim,
    input logic [NUM_REQ*CNT_W-1:0] occ_flat
);
    int occ_sum;
    always_comb begin
        occ_sum = 0;
        for (int r = 0; r < NUM_REQ; r++) occ_sum += int'(occ_flat[r*CNT_W +: CNT_W]);
    end

    p_lim_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_lim != '0) && (alloc_lim <= LIM_W'(WAYS)));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_accept_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_hit_in_lim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ({1'b0, rsp_way} < $past(alloc_lim)));

    p_victim_in_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ({1'b0, rsp_victim} < $past(alloc_lim)));

    p_seq_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (SEQ_ACCESS && rsp_valid && !rsp_hit) |-> (rsp_dreads == '0));

    p_lat_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_lat >= LAT_W'(ACC_LAT)));

    p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ_sum <= SETS * WAYS);

endmodule

bind set_assoc_tags sat_chk #(
    .SETS       (SETS),
    .WAYS       (WAYS),
    .NUM_REQ    (NUM_REQ),
    .ACC_LAT    (ACC_LAT),
    .SEQ_ACCESS (SEQ_ACCESS),
    .WAY_W      (WAY_W),
    .LIM_W      (LIM_W),
    .CNT_W      (CNT_W),
    .LAT_W      (LAT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_victim (rsp_victim),
    .rsp_lat    (rsp_lat),
    .rsp_treads (rsp_treads),
    .rsp_dreads (rsp_dreads),
    .alloc_lim  (alloc_lim),
    .occ_flat   (occ_flat)
);

// File: tb/set_assoc_tags_tb_top.sv
`timescale 1ns/1ps
module set_assoc_tags_tb_top;
    localparam int NS = 16, NW = 4, NR = 4, CW = 7, ACC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_id = '0;
    logic [3:0]  req_wait = '0;
    logic        lim_we = 1'b0;
    logic [2:0]  lim_val = '0;
    logic [3:0]  rb_set = '0;
    logic [1:0]  rb_way = '0;

    logic        req_ready, rsp_valid, rsp_hit, rb_valid;
    logic [1:0]  rsp_way, rsp_victim, rb_owner;
    logic [4:0]  rsp_lat;
    logic [2:0]  rsp_treads, rsp_dreads, alloc_lim;
    logic [31:0] rb_addr;
    logic [NR*CW-1:0] occ_flat;

    logic        p_ready, p_valid, p_hit, p_rbv;
    logic [1:0]  p_way, p_vic, p_own;
    logic [4:0]  p_lat;
    logic [2:0]  p_tr, p_dr, p_lim;
    logic [31:0] p_rba;
    logic [NR*CW-1:0] p_occ;

    set_assoc_tags #(.SEQ_ACCESS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_id(req_id), .req_wait(req_wait),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim(rsp_victim), .rsp_lat(rsp_lat), .rsp_treads(rsp_treads),
        .rsp_dreads(rsp_dreads), .lim_we(lim_we), .lim_val(lim_val),
        .alloc_lim(alloc_lim), .rb_set(rb_set), .rb_way(rb_way), .rb_addr(rb_addr),
        .rb_valid(rb_valid), .rb_owner(rb_owner), .occ_flat(occ_flat));

    set_assoc_tags #(.SEQ_ACCESS(1'b0)) dut_par_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(p_ready),
        .req_op(req_op), .req_addr(req_addr), .req_id(req_id), .req_wait(req_wait),
        .rsp_valid(p_valid), .rsp_hit(p_hit), .rsp_way(p_way),
        .rsp_victim(p_vic), .rsp_lat(p_lat), .rsp_treads(p_tr),
        .rsp_dreads(p_dr), .lim_we(lim_we), .lim_val(lim_val),
        .alloc_lim(p_lim), .rb_set(rb_set), .rb_way(rb_way), .rb_addr(p_rba),
        .rb_valid(p_rbv), .rb_owner(p_own), .occ_flat(p_occ));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    int m_valid[NS][NW];
    int m_tag[NS][NW];
    int m_owner[NS][NW];
    int m_pend[NS][NW];
    int m_ord[NS][NW];   // position 0 = most recent
    int m_occ[NR];
    int m_lim;

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                m_pend[s][w] = (m_pend[s][w] > n) ? m_pend[s][w] - n : 0;
    endtask

    task automatic touch(input int s, input int w);
        int p;
        p = 0;
        for (int i = 0; i < NW; i++) if (m_ord[s][i] == w) p = i;
        for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
        m_ord[s][0] = w;
    endtask

    // op: 0 access 1 probe 2 fill 3 invalidate
    task automatic op(input int o, input int tg, input int s, input int off,
                      input int id, input int wt);
        int e_hit, e_way, e_vic, e_lat, e_tr, e_dr, e_pdr, tgt;
        tick(1);
        e_hit = 0; e_way = 0;
        for (int w = NW - 1; w >= 0; w--)
            if (w < m_lim && m_valid[s][w] != 0 && m_tag[s][w] == tg) begin
                e_hit = 1; e_way = w;
            end
        e_vic = -1;
        for (int w = NW - 1; w >= 0; w--)
            if (w < m_lim && m_valid[s][w] == 0) e_vic = w;
        if (e_vic < 0)
            for (int i = 0; i < NW; i++)
                if (m_ord[s][i] < m_lim) e_vic = m_ord[s][i];
        e_lat = (e_hit != 0 && m_pend[s][e_way] > ACC) ? m_pend[s][e_way] + ACC : ACC;
        e_tr  = (o < 2) ? m_lim : 0;
        e_dr  = (o < 2) ? e_hit : 0;
        e_pdr = (o < 2) ? m_lim : 0;
        tgt   = e_hit ? e_way : e_vic;

        req_op = 2'(o);
        req_addr = (32'(tg) << 10) | (32'(s) << 6) | 32'(off);
        req_id = 2'(id);
        req_wait = 4'(wt);
        req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R3", "ready low in exec", int'(req_ready), 0);
        @(posedge clk); @(negedge clk);
        check("R3", "rsp_valid", int'(rsp_valid), 1);
        check("R3", "rsp_hit", int'(rsp_hit), e_hit);
        if (e_hit != 0 || o == 2) check("R3", "rsp_way", int'(rsp_way), tgt);
        check("R4", "rsp_victim", int'(rsp_victim), e_vic);
        check("R12", "rsp_lat", int'(rsp_lat), e_lat);
        check("R9", "treads", int'(rsp_treads), e_tr);
        check("R9", "seq dreads", int'(rsp_dreads), e_dr);
        check("R9", "par dreads", int'(p_dr), e_pdr);

        tick(1);
        if (o == 0 && e_hit != 0) touch(s, e_way);
        if (o == 2) begin
            if (m_valid[s][tgt] != 0) m_occ[m_owner[s][tgt]]--;
            m_valid[s][tgt] = 1; m_tag[s][tgt] = tg; m_owner[s][tgt] = id;
            m_pend[s][tgt] = wt; m_occ[id]++;
            touch(s, tgt);
        end
        if (o == 3 && e_hit != 0) begin
            m_occ[m_owner[s][e_way]]--;
            m_valid[s][e_way] = 0; m_owner[s][e_way] = 0; m_pend[s][e_way] = 0;
        end
    endtask

    task automatic set_lim(input int v);
        lim_val = 3'(v); lim_we = 1'b1;
        @(posedge clk); @(negedge clk);
        lim_we = 1'b0;
        tick(1);
        if (v >= 1 && v <= NW) m_lim = v;
        check("R7", "alloc_lim", int'(alloc_lim), m_lim);
    endtask

    task automatic check_occ(input string rq);
        for (int r = 0; r < NR; r++)
            check(rq, "occupancy", int'(occ_flat[r*CW +: CW]), m_occ[r]);
    endtask

    task automatic check_rb(input int s, input int w, input string rq);
        rb_set = 4'(s); rb_way = 2'(w);
        #1;
        check(rq, "rb_valid", int'(rb_valid), m_valid[s][w]);
        if (m_valid[s][w] != 0) begin
            check("R2", "rb_addr", int'(rb_addr), (m_tag[s][w] << 10) | (s << 6));
            check(rq, "rb_owner", int'(rb_owner), m_owner[s][w]);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_lim = NW;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_owner[s][w] = 0;
                m_pend[s][w] = 0; m_ord[s][w] = w;
            end
        for (int r = 0; r < NR; r++) m_occ[r] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        check("R13", "req_ready", int'(req_ready), 1);
        check("R13", "rsp_valid", int'(rsp_valid), 0);
        check("R7", "reset limit", int'(alloc_lim), NW);
        check_occ("R13");
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) check_rb(s, w, "R13");

        // R5/R4/R10: fill every line; victims walk the invalid ways upward
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NW; k++)
                op(2, 100 + s * NW + k, s, (k * 13) % 64, (s + k) % NR, 0);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) check_rb(s, w, "R10");
        check_occ("R10");

        // R1: offset bits ignored, hits in each set with varied access order
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NW; k++)
                op(0, 100 + s * NW + ((k + s) % NW), s, 63 - k, 0, 0);
        // R5: misses expose LRU victim in full sets
        for (int s = 0; s < NS; s++) op(1, 9000 + s, s, 0, 0, 0);

        // R6: probing the LRU line does not refresh it
        op(1, m_tag[5][m_ord[5][NW-1]], 5, 0, 0, 0);
        op(1, 7777, 5, 0, 0, 0);
        op(0, m_tag[5][m_ord[5][NW-1]], 5, 0, 0, 0);
        op(1, 7777, 5, 0, 0, 0);

        // R7/R8: limit handling
        set_lim(0);
        set_lim(5);
        set_lim(2);
        op(0, m_tag[6][3], 6, 0, 0, 0);          // R8 way 3 masked
        op(0, m_tag[6][1], 6, 0, 0, 0);
        op(2, 5555, 6, 0, 3, 0);                  // R10 eviction below limit
        check_rb(6, 0, "R10"); check_rb(6, 1, "R10");
        check_occ("R10");
        set_lim(4);

        // R11: invalidate hit and miss
        op(3, m_tag[3][2], 3, 0, 0, 0);
        check_rb(3, 2, "R11");
        check_occ("R11");
        op(3, 4321, 3, 0, 0, 0);
        check_occ("R11");
        op(1, 4444, 3, 0, 0, 0);                  // R4 invalid way preferred

        // R12: pending fill latency
        op(2, 6000, 3, 0, 1, 15);
        op(0, 6000, 3, 5, 0, 0);
        op(0, 6000, 3, 9, 0, 0);
        op(1, 6000, 3, 0, 0, 0);
        op(3, m_tag[8][0], 8, 0, 0, 0);
        op(2, 6100, 8, 0, 2, 3);
        op(0, 6100, 8, 0, 0, 0);
        check_occ("R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule